// File: doc/BRIEF.md
# Bidirectional Word Mailbox with Interrupt

This block is a single 32-bit mailbox shared between a host CPU bus and a word-oriented link to a PC. When the host writes a word, the block raises an outbound transfer request that carries that word to the link. When the link delivers a word, the block stores it for the host to read and marks an event as pending. If the host has enabled the interrupt, a pending event raises the cart interrupt line. The host acknowledges the event by writing the acknowledge bit of the control port.

There is no flow control in either direction, so the mailbox is meant for ping-pong use: one side sends a word, the other reads it and sends a reply. A newer word always replaces an older one. Interrupt state (pending and enable) is wiped by a hard reset, an NMI reset or a register-lock event. The interrupt output is held low whenever register access is disabled.

Two state machines form the block. The outbound machine has states `TX_IDLE` and `TX_SEND`. A host write takes it from `TX_IDLE` to `TX_SEND`, or keeps it in `TX_SEND`. It returns to `TX_IDLE` when the link accepts the word and no new write arrives in the same cycle. The event machine has states `EV_CLEAR` and `EV_PENDING`. An inbound word moves it to `EV_PENDING`. An acknowledge with no inbound word moves it back to `EV_CLEAR`. A wipe (NMI reset or lock) forces `EV_CLEAR` from either state.

Top module: `xfer_mailbox`

## Requirements
- R1: After hard reset, `out_valid`, `pending_o`, `irq_en_o` and `irq_o` are 0 and `host_rd_data` is 0.
- R2: A host write (`host_wr`=1) sets `out_valid`=1 on the next cycle, with `out_data` and `host_rd_data` both equal to the written word.
- R3: While `out_valid`=1 and `out_ready`=0, the request stays asserted and `out_data` is stable. The cycle after `out_valid` and `out_ready` are both 1 with no host write, `out_valid` is 0.
- R4: A host write while a request is outstanding replaces the outbound word and keeps `out_valid`=1. This also holds when the write falls in the link's accept cycle.
- R5: An inbound word (`in_valid`=1) is stored and returned on `host_rd_data` on the next cycle, and sets `pending_o`. A later inbound word overwrites the stored one.
- R6: `irq_o` is 1 exactly when `pending_o`, `irq_en_o` and `reg_access_en` are all 1.
- R7: A control write with `ctl_ack`=1 clears `pending_o` on the next cycle. If an inbound word arrives in the same cycle, `pending_o` stays 1.
- R8: A control write with `ctl_ie_set`=1 sets `irq_en_o`, and one with `ctl_ie_clr`=1 clears it. When both are 1, clear wins.
- R9: A pulse on `nmi_rst` or `reg_lock` clears `pending_o` and `irq_en_o` on the next cycle, even when an inbound word arrives in the same cycle. The inbound word is still stored.
- R10: While `reg_access_en`=0, `irq_o` is 0 but pending and enable state are kept. Re-enabling access restores `irq_o`.
- R11: When a host write and an inbound word fall in the same cycle, `host_rd_data` takes the inbound word and `out_data` carries the host word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| nmi_rst | input | 1 | NMI reset pulse, wipes interrupt state |
| reg_lock | input | 1 | Register-lock pulse, wipes interrupt state |
| reg_access_en | input | 1 | Register access enabled; gates the interrupt |
| host_wr | input | 1 | Host write strobe to the mailbox word |
| host_wr_data | input | 32 | Host write data |
| host_rd_data | output | 32 | Stored mailbox word |
| ctl_wr | input | 1 | Control write strobe |
| ctl_ack | input | 1 | Control: acknowledge pending event |
| ctl_ie_set | input | 1 | Control: set interrupt enable |
| ctl_ie_clr | input | 1 | Control: clear interrupt enable |
| pending_o | output | 1 | Event pending status |
| irq_en_o | output | 1 | Interrupt enable status |
| irq_o | output | 1 | Cart interrupt request |
| out_valid | output | 1 | Outbound word valid |
| out_data | output | 32 | Outbound word |
| out_ready | input | 1 | Link accepts outbound word |
| in_valid | input | 1 | Inbound word strobe, always accepted |
| in_data | input | 32 | Inbound word |

## Verification
Several pairs of functions can fall in the same cycle:
- an acknowledge write and an inbound word;
- a wipe pulse and an inbound word;
- enable set and enable clear;
- a host write and an inbound word;
- a host write and the link's accept of the previous word.

The bench provokes each pair by driving both stimuli in one cycle. It then judges the result one cycle later at the ports: pending, enable, stored word, outbound valid and outbound data are compared with the winner that the requirements name.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic {
        TX_IDLE,
        TX_SEND
    } tx_state_e;

    typedef enum logic {
        EV_CLEAR,
        EV_PENDING
    } ev_state_e;

endpackage

// File: rtl/mbx_tx_fsm.sv
module mbx_tx_fsm
    import mbx_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              ready,
    output logic              valid,
    output logic [WORD_W-1:0] data
);

    tx_state_e         state_q, state_d;
    logic [WORD_W-1:0] word_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (wr) state_d = TX_SEND;
            TX_SEND: begin
                if (wr)         state_d = TX_SEND;
                else if (ready) state_d = TX_IDLE;
            end
            default: state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            if (wr) word_q <= wr_data;
        end
    end

    always_comb begin
        valid = (state_q == TX_SEND);
        data  = word_q;
    end

    // R2: a write presents its word on the next cycle
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (valid && data == $past(wr_data)));

    // R3: unaccepted request holds its word
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready && !wr) |=> (valid && $stable(data)));

    // R3: accepted request without new write drops
    a_r3_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready && !wr) |=> !valid);

endmodule

// File: rtl/mbx_evt_fsm.sv
module mbx_evt_fsm
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wipe,
    input  logic in_evt,
    input  logic ack,
    input  logic ie_set,
    input  logic ie_clr,
    output logic pending,
    output logic enable
);

    ev_state_e state_q, state_d;
    logic      ie_q, ie_d;

    always_comb begin
        state_d = state_q;
        if (wipe) begin
            state_d = EV_CLEAR;
        end else begin
            unique case (state_q)
                EV_CLEAR:   if (in_evt) state_d = EV_PENDING;
                EV_PENDING: if (!in_evt && ack) state_d = EV_CLEAR;
                default:    state_d = EV_CLEAR;
            endcase
        end
    end

    always_comb begin
        ie_d = ie_q;
        if (wipe || ie_clr) ie_d = 1'b0;
        else if (ie_set)    ie_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EV_CLEAR;
            ie_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            ie_q    <= ie_d;
        end
    end

    always_comb begin
        pending = (state_q == EV_PENDING);
        enable  = ie_q;
    end

    // R5: inbound word raises pending unless wiped
    a_r5_set: assert property (@(posedge clk) disable iff (!rst_n)
        (in_evt && !wipe) |=> pending);

    // R7: lone acknowledge clears pending
    a_r7_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !in_evt && !wipe) |=> !pending);

    // R9: wipe clears both pending and enable
    a_r9_wipe: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> (!pending && !enable));

    // R8: clear beats set
    a_r8_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ie_clr |=> !enable);

endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [WORD_W-1:0] host_data,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic [WORD_W-1:0] word
);

    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        word_q <= '0;
        else if (in_valid) word_q <= in_data;
        else if (host_wr)  word_q <= host_data;
    end

    assign word = word_q;

    // R11: inbound word wins over a same-cycle host write
    a_r11_inbound_wins: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (word == $past(in_data)));

endmodule

// File: rtl/xfer_mailbox.sv
module xfer_mailbox #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_rst,
    input  logic              reg_lock,
    input  logic              reg_access_en,
    input  logic              host_wr,
    input  logic [WORD_W-1:0] host_wr_data,
    output logic [WORD_W-1:0] host_rd_data,
    input  logic              ctl_wr,
    input  logic              ctl_ack,
    input  logic              ctl_ie_set,
    input  logic              ctl_ie_clr,
    output logic              pending_o,
    output logic              irq_en_o,
    output logic              irq_o,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    input  logic              out_ready,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data
);

    logic wipe;
    logic ack_eff, set_eff, clr_eff;

    assign wipe    = nmi_rst | reg_lock;
    assign ack_eff = ctl_wr & ctl_ack;
    assign set_eff = ctl_wr & ctl_ie_set;
    assign clr_eff = ctl_wr & ctl_ie_clr;

    mbx_tx_fsm #(.WORD_W(WORD_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (host_wr),
        .wr_data (host_wr_data),
        .ready   (out_ready),
        .valid   (out_valid),
        .data    (out_data)
    );

    mbx_evt_fsm u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wipe    (wipe),
        .in_evt  (in_valid),
        .ack     (ack_eff),
        .ie_set  (set_eff),
        .ie_clr  (clr_eff),
        .pending (pending_o),
        .enable  (irq_en_o)
    );

    mbx_store #(.WORD_W(WORD_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr   (host_wr),
        .host_data (host_wr_data),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .word      (host_rd_data)
    );

    assign irq_o = pending_o & irq_en_o & reg_access_en;

    // R10: no interrupt while access is disabled
    a_r10_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_access_en |-> !irq_o);

    // R6: interrupt implies a pending, enabled event
    a_r6_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pending_o && irq_en_o));

endmodule

// File: tb/test_xfer_mailbox.sv
`timescale 1ns/1ps
module test_xfer_mailbox;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_rst = 1'b0, reg_lock = 1'b0, reg_access_en = 1'b1;
    logic        host_wr = 1'b0;
    logic [31:0] host_wr_data = '0;
    logic [31:0] host_rd_data;
    logic        ctl_wr = 1'b0, ctl_ack = 1'b0, ctl_ie_set = 1'b0, ctl_ie_clr = 1'b0;
    logic        pending_o, irq_en_o, irq_o, out_valid;
    logic [31:0] out_data;
    logic        out_ready = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    xfer_mailbox i_xfer_mailbox (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic ctl(input logic ack, input logic s, input logic c);
        ctl_wr = 1'b1; ctl_ack = ack; ctl_ie_set = s; ctl_ie_clr = c;
        step();
        ctl_wr = 1'b0; ctl_ack = 1'b0; ctl_ie_set = 1'b0; ctl_ie_clr = 1'b0;
    endtask

    task automatic push_in(input logic [31:0] w);
        in_valid = 1'b1; in_data = w;
        step();
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 out_valid", out_valid, 0);
        check("R1 pending", pending_o, 0);
        check("R1 enable", irq_en_o, 0);
        check("R1 irq", irq_o, 0);
        check("R1 rd_data", host_rd_data, 0);
    endtask

    task automatic t_outbound();
        host_wr = 1'b1; host_wr_data = 32'hA5A5_0001;
        step();
        host_wr = 1'b0;
        check("R2 out_valid", out_valid, 1);
        check("R2 out_data", out_data, 32'hA5A5_0001);
        check("R2 rd_data", host_rd_data, 32'hA5A5_0001);
        step(); step();
        check("R3 held valid", out_valid, 1);
        check("R3 held data", out_data, 32'hA5A5_0001);
        out_ready = 1'b1;
        step();
        out_ready = 1'b0;
        check("R3 dropped", out_valid, 0);
    endtask

    task automatic t_replace();
        host_wr = 1'b1; host_wr_data = 32'h0000_00B0;
        step();
        host_wr_data = 32'h0000_00C0;
        step();
        host_wr = 1'b0;
        check("R4 replace valid", out_valid, 1);
        check("R4 replace data", out_data, 32'h0000_00C0);
        host_wr = 1'b1; host_wr_data = 32'h0000_00D0; out_ready = 1'b1;
        step();
        host_wr = 1'b0;
        check("R4 accept+write valid", out_valid, 1);
        check("R4 accept+write data", out_data, 32'h0000_00D0);
        step();
        out_ready = 1'b0;
        check("R3 drop after final", out_valid, 0);
    endtask

    task automatic t_inbound();
        push_in(32'h1111_1111);
        check("R5 stored", host_rd_data, 32'h1111_1111);
        check("R5 pending", pending_o, 1);
        check("R6 no irq disabled", irq_o, 0);
        push_in(32'h2222_2222);
        check("R5 overwrite", host_rd_data, 32'h2222_2222);
        ctl(1'b0, 1'b1, 1'b0);
        check("R8 enable set", irq_en_o, 1);
        check("R6 irq raised", irq_o, 1);
        ctl(1'b1, 1'b0, 1'b0);
        check("R7 ack clears", pending_o, 0);
        check("R6 irq low after ack", irq_o, 0);
    endtask

    task automatic t_collisions();
        push_in(32'h3333_0000);
        ctl_wr = 1'b1; ctl_ack = 1'b1; in_valid = 1'b1; in_data = 32'h3333_0001;
        step();
        ctl_wr = 1'b0; ctl_ack = 1'b0; in_valid = 1'b0;
        check("R7 ack vs inbound pending", pending_o, 1);
        check("R7 ack vs inbound data", host_rd_data, 32'h3333_0001);
        ctl(1'b0, 1'b1, 1'b1);
        check("R8 clear wins", irq_en_o, 0);
        host_wr = 1'b1; host_wr_data = 32'h7777_7777;
        in_valid = 1'b1; in_data = 32'h8888_8888;
        step();
        host_wr = 1'b0; in_valid = 1'b0;
        check("R11 rd inbound", host_rd_data, 32'h8888_8888);
        check("R11 out host", out_data, 32'h7777_7777);
        out_ready = 1'b1; step(); out_ready = 1'b0;
    endtask

    task automatic t_wipe(input bit use_lock);
        ctl(1'b0, 1'b1, 1'b0);
        push_in(32'h4444_0000);
        check("R9 armed irq", irq_o, 1);
        if (use_lock) reg_lock = 1'b1; else nmi_rst = 1'b1;
        in_valid = 1'b1; in_data = 32'h4444_0001;
        step();
        reg_lock = 1'b0; nmi_rst = 1'b0; in_valid = 1'b0;
        check("R9 pending wiped", pending_o, 0);
        check("R9 enable wiped", irq_en_o, 0);
        check("R9 data kept", host_rd_data, 32'h4444_0001);
    endtask

    task automatic t_access();
        ctl(1'b0, 1'b1, 1'b0);
        push_in(32'h5555_5555);
        reg_access_en = 1'b0;
        #1;
        check("R10 irq gated", irq_o, 0);
        check("R10 pending kept", pending_o, 1);
        step();
        check("R10 enable kept", irq_en_o, 1);
        reg_access_en = 1'b1;
        #1;
        check("R10 irq restored", irq_o, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #12;
        t_reset();
        rst_n = 1'b1;
        step();
        t_outbound();
        t_replace();
        t_inbound();
        t_collisions();
        t_wipe(1'b0);
        t_wipe(1'b1);
        t_access();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule